// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This unit sits between a USB host controller's schedule walker and its packet issuer. When the walker has fetched one transfer descriptor, it presents the descriptor's control word and token word. The unit decodes the token straight away, with no register in the path, so the issuer can start the bus transaction. When the transaction result is known, the walker presents the same two words again with the result. The result is a received byte count or one of five outcomes: no device, NAK, stall, babble or pending. One clock later the unit returns four things:

- the updated control word, with a write-back strobe;
- a return code that tells the walker whether to advance the queue, skip it, wait or abort the frame;
- the interrupt flags for the end of the frame;
- one-cycle pulses for the error-interrupt event and the process-error event.

The unit applies these rules:

- It clamps an over-long IN reception to the descriptor's maximum and treats it as babble.
- It runs the two-bit retry counter down on timeouts.
- It treats a NAK on a SETUP token as a timeout.
- It stops a queue when short-packet detection catches a short IN packet.

It holds no state besides its output register.

Top module: `td_status_update`

Control-word bits used throughout:

| Bit(s) | Meaning |
|---|---|
| 29 | short-packet detect |
| 28:27 | retry counter |
| 25 | isochronous |
| 24 | interrupt on complete |
| 23 | active |
| 22 | stalled |
| 20 | babble |
| 19 | NAK |
| 18 | timeout |
| 10:0 | actual length minus one |

Encodings:

- **Result kind (`res_kind`):** 0 byte count, 1 no device, 2 NAK, 3 stall, 4 babble, 5 pending. The values 6 and 7 are handled as no device.
- **Return code (`ret_code`):** 0 advance, 1 skip, 2 pending, 3 abort frame.
- **PIDs:** 0x69 IN, 0xE1 OUT, 0x2D SETUP.

## Requirements
- R1: Token decode is combinational from `token_in`: PID = bits 7:0, device address = bits 14:8, endpoint = bits 18:15, maximum length = (bits 31:21 + 1) modulo 2048, so a field of 0x7FF gives a maximum of 0.
- R2: If control bit 24 is set, interrupt flag bit 0 is set in the result, whatever the active bit, the PID or the transaction result.
- R3: A descriptor with bit 23 clear returns code 1 and an unchanged control word.
- R4: An active descriptor whose PID is not 0x69, 0xE1 or 0x2D pulses `perr_evt`, returns code 3 and leaves the control word unchanged.
- R5: An active descriptor with result kind 5 returns code 2 and an unchanged control word, even when bit 25 is set.
- R6: A successful transfer writes (length - 1) mod 2048 into bits 10:0 and clears bits 23 and 19. For OUT and SETUP the length is the maximum length. For IN it is the received count. The return code is 0 unless R8 applies.
- R7: An IN count larger than the maximum length is treated as the babble result of R12.
- R8: A successful IN with bit 29 set and a count below the maximum sets interrupt flag bit 1 and returns code 1.
- R9: No device (kind 1, 6 or 7) sets bit 18 and decrements a non-zero retry counter. When the counter falls from 1 to 0, bit 23 is cleared and `err_evt` pulses. A counter of 0 stays 0 and leaves bit 23 set. The return code is 1.
- R10: A NAK sets bit 19 and returns code 1. A NAK on a SETUP PID additionally takes the full timeout path of R9.
- R11: A stall sets bit 22, clears bit 23 and returns code 1.
- R12: Babble sets bits 20 and 22, clears bit 23 and returns code 3.
- R13: With bit 25 set and a non-pending result, bit 23 is cleared whatever the outcome.
- R14: Results appear on the clock after `in_valid`, together with a one-cycle `out_valid`. `wb_en` is high exactly when the new control word differs from the one presented. All outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Descriptor and result presented |
| ctrl_in | input | 32 | Descriptor control word |
| token_in | input | 32 | Descriptor token word |
| res_kind | input | 3 | Transaction result kind |
| res_count | input | 12 | Byte count received (IN, kind 0) |
| tok_pid | output | 8 | Decoded PID |
| tok_addr | output | 7 | Decoded device address |
| tok_ep | output | 4 | Decoded endpoint |
| tok_maxlen | output | 11 | Decoded maximum length |
| out_valid | output | 1 | Result valid |
| ctrl_out | output | 32 | Updated control word |
| ret_code | output | 2 | Return code |
| irq_flags | output | 2 | Interrupt flags (bit 0 complete, bit 1 short packet) |
| err_evt | output | 1 | Retry counter exhausted |
| perr_evt | output | 1 | Invalid PID on an active descriptor |
| wb_en | output | 1 | Control word changed, write back |

## Verification
The hardest corners to reach are those where two rules interact. Examples are a SETUP NAK whose retry counter is exactly 1, an isochronous descriptor whose result is pending, and an IN count one past a maximum length that has wrapped to zero. Directed vectors set up each of these combinations exactly. A long run of mixed words then goes through the bench's own model on every clock. That run draws retry counters, flag bits, PIDs (valid and invalid) and result kinds, including the reserved ones.

// File: rtl/td_status_update.sv
module td_status_update #(
  parameter int LENW = 11,
  parameter int CNTW = LENW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     ctrl_in,
  input  logic [31:0]     token_in,
  input  logic [2:0]      res_kind,
  input  logic [CNTW-1:0] res_count,
  output logic [7:0]      tok_pid,
  output logic [6:0]      tok_addr,
  output logic [3:0]      tok_ep,
  output logic [LENW-1:0] tok_maxlen,
  output logic            out_valid,
  output logic [31:0]     ctrl_out,
  output logic [1:0]      ret_code,
  output logic [1:0]      irq_flags,
  output logic            err_evt,
  output logic            perr_evt,
  output logic            wb_en
);
  localparam logic [7:0] PID_IN = 8'h69, PID_OUT = 8'hE1, PID_SETUP = 8'h2D;
  localparam logic [2:0] K_CNT = 3'd0, K_NAK = 3'd2, K_STALL = 3'd3,
                         K_BABBLE = 3'd4, K_PEND = 3'd5;
  localparam logic [1:0] RC_ADV = 2'd0, RC_SKIP = 2'd1, RC_PEND = 2'd2, RC_ABORT = 2'd3;
  localparam int B_SPD = 29, B_ERR = 27, B_ISO = 25, B_IOC = 24, B_ACT = 23,
                 B_STALL = 22, B_BABBLE = 20, B_NAK = 19, B_TMO = 18;

  assign tok_pid    = token_in[7:0];
  assign tok_addr   = token_in[14:8];
  assign tok_ep     = token_in[18:15];
  assign tok_maxlen = token_in[31:21] + 11'd1;

  wire is_in    = tok_pid == PID_IN;
  wire is_setup = tok_pid == PID_SETUP;
  wire pid_ok   = is_in || is_setup || tok_pid == PID_OUT;
  wire [CNTW-1:0] max_ext = {1'b0, tok_maxlen};

  logic [31:0]     nxt;
  logic [1:0]      rc, fl;
  logic            eev, pev, tmo;
  logic [2:0]      kind;
  logic [CNTW-1:0] len, len_m1;
  logic [1:0]      err;

  always_comb begin
    nxt  = ctrl_in;
    rc   = RC_SKIP;
    fl   = {1'b0, ctrl_in[B_IOC]};
    eev  = 1'b0;
    pev  = 1'b0;
    tmo  = 1'b0;
    kind = res_kind;
    len  = '0;
    err  = ctrl_in[B_ERR+1:B_ERR];
    if (ctrl_in[B_ACT]) begin
      if (!pid_ok) begin
        pev = 1'b1;
        rc  = RC_ABORT;
      end else begin
        if (res_kind == K_CNT) begin
          if (!is_in) len = max_ext;
          else if (res_count > max_ext) begin
            len  = max_ext;
            kind = K_BABBLE;
          end else len = res_count;
        end
        if (kind == K_PEND) rc = RC_PEND;
        else begin
          if (ctrl_in[B_ISO]) nxt[B_ACT] = 1'b0;
          case (kind)
            K_CNT: begin
              nxt[LENW-1:0] = len_m1[LENW-1:0];
              nxt[B_ACT] = 1'b0;
              nxt[B_NAK] = 1'b0;
              if (is_in && ctrl_in[B_SPD] && len < max_ext) begin
                fl[1] = 1'b1;
                rc    = RC_SKIP;
              end else rc = RC_ADV;
            end
            K_NAK: begin
              nxt[B_NAK] = 1'b1;
              tmo = is_setup;
            end
            K_STALL: begin
              nxt[B_STALL] = 1'b1;
              nxt[B_ACT]   = 1'b0;
            end
            K_BABBLE: begin
              nxt[B_BABBLE] = 1'b1;
              nxt[B_STALL]  = 1'b1;
              nxt[B_ACT]    = 1'b0;
              rc = RC_ABORT;
            end
            default: tmo = 1'b1;
          endcase
          if (tmo) begin
            nxt[B_TMO] = 1'b1;
            if (err != 2'd0) begin
              nxt[B_ERR+1:B_ERR] = err - 2'd1;
              if (err == 2'd1) begin
                nxt[B_ACT] = 1'b0;
                eev = 1'b1;
              end
            end
            rc = RC_SKIP;
          end
        end
      end
    end
  end

  assign len_m1 = len - {{(CNTW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ctrl_out  <= '0;
      ret_code  <= '0;
      irq_flags <= '0;
      err_evt   <= 1'b0;
      perr_evt  <= 1'b0;
      wb_en     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      err_evt   <= in_valid && eev;
      perr_evt  <= in_valid && pev;
      wb_en     <= in_valid && (nxt != ctrl_in);
      if (in_valid) begin
        ctrl_out  <= nxt;
        ret_code  <= rc;
        irq_flags <= fl;
      end
    end
  end

  p_inactive_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !ctrl_in[B_ACT] |=> ctrl_out == $past(ctrl_in) && ret_code == RC_SKIP && !wb_en);

  p_ioc_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ctrl_in[B_IOC] |=> irq_flags[0]);

  p_perr_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    perr_evt |-> out_valid && ret_code == RC_ABORT && !wb_en && !err_evt);

  p_pending_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ret_code == RC_PEND |-> !wb_en && ctrl_out[B_ACT]);

  p_advance_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ret_code == RC_ADV |-> !ctrl_out[B_ACT] && !ctrl_out[B_NAK]);

  p_err_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |-> !ctrl_out[B_ACT] && ctrl_out[B_TMO] && ctrl_out[B_ERR+1:B_ERR] == 2'd0);

  p_strobe_one_cycle_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !wb_en && !err_evt && !perr_evt);
endmodule

// File: tb/tb_td_status_update.sv
`timescale 1ns/1ps
module tb_td_status_update;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [31:0] ctrl_in = '0, token_in = '0;
  logic [2:0]  res_kind = '0;
  logic [11:0] res_count = '0;
  logic [7:0]  tok_pid;
  logic [6:0]  tok_addr;
  logic [3:0]  tok_ep;
  logic [10:0] tok_maxlen;
  logic        out_valid, err_evt, perr_evt, wb_en;
  logic [31:0] ctrl_out;
  logic [1:0]  ret_code, irq_flags;

  int checks = 0, bad = 0;
  bit done = 0;
  string cur_req = "R14";

  always #2.5 clk = ~clk;

  td_status_update dut (.*);

  function automatic void model(input logic [31:0] c, t, input logic [2:0] k,
      input logic [11:0] n, output logic [31:0] co, output logic [1:0] rc,
      output logic [1:0] fl, output logic e, output logic p);
    int ml, len, pid, kk, er;
    bit tmo;
    ml = ((t >> 21) + 1) & 'h7ff;
    pid = t & 'hff;
    co = c; fl = 2'b00; e = 0; p = 0; rc = 1; tmo = 0;
    if (c[24]) fl[0] = 1;
    if (!c[23]) return;
    if (pid != 'h69 && pid != 'hE1 && pid != 'h2D) begin p = 1; rc = 3; return; end
    kk = k; len = 0;
    if (k == 0) begin
      if (pid == 'h69) begin
        len = n;
        if (len > ml) begin len = ml; kk = 4; end
      end else len = ml;
    end
    if (kk == 5) begin rc = 2; return; end
    if (c[25]) co[23] = 0;
    if (kk == 0) begin
      co[10:0] = 11'((len - 1) & 'h7ff);
      co[23] = 0; co[19] = 0;
      if (pid == 'h69 && c[29] && len < ml) begin fl[1] = 1; rc = 1; end
      else rc = 0;
    end else if (kk == 2) begin
      co[19] = 1; rc = 1;
      if (pid == 'h2D) tmo = 1;
    end else if (kk == 3) begin
      co[22] = 1; co[23] = 0; rc = 1;
    end else if (kk == 4) begin
      co[20] = 1; co[22] = 1; co[23] = 0; rc = 3;
    end else tmo = 1;
    if (tmo) begin
      co[18] = 1;
      er = c[28:27];
      if (er != 0) begin
        er--;
        if (er == 0) begin co[23] = 0; e = 1; end
      end
      co[28:27] = 2'(er);
      rc = 1;
    end
  endfunction

  logic        x_valid, x_e, x_p, x_wb;
  logic [31:0] x_ctrl;
  logic [1:0]  x_rc, x_fl;
  string       x_req;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_valid <= 0; x_ctrl <= 0; x_rc <= 0; x_fl <= 0; x_e <= 0; x_p <= 0; x_wb <= 0;
      x_req <= "R14";
    end else begin
      logic [31:0] co; logic [1:0] rc, fl; logic e, p;
      model(ctrl_in, token_in, res_kind, res_count, co, rc, fl, e, p);
      x_valid <= in_valid;
      x_e <= in_valid && e;
      x_p <= in_valid && p;
      x_wb <= in_valid && (co != ctrl_in);
      x_req <= cur_req;
      if (in_valid) begin x_ctrl <= co; x_rc <= rc; x_fl <= fl; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (out_valid !== x_valid || ctrl_out !== x_ctrl || ret_code !== x_rc ||
          irq_flags !== x_fl || err_evt !== x_e || perr_evt !== x_p || wb_en !== x_wb) begin
        bad++;
        $display("FAIL %s: act v=%b ctrl=%h rc=%0d fl=%b e=%b p=%b wb=%b exp v=%b ctrl=%h rc=%0d fl=%b e=%b p=%b wb=%b",
          x_req, out_valid, ctrl_out, ret_code, irq_flags, err_evt, perr_evt, wb_en,
          x_valid, x_ctrl, x_rc, x_fl, x_e, x_p, x_wb);
      end
    end
  end

  function automatic logic [31:0] tok(input logic [7:0] pid, input logic [6:0] a,
      input logic [3:0] ep, input logic [10:0] mf);
    return {mf, 2'b00, ep, a, pid};
  endfunction

  function automatic logic [31:0] ctl(input bit spd, input logic [1:0] er, input bit iso,
      input bit ioc, input bit act);
    logic [31:0] c = '0;
    c[29] = spd; c[28:27] = er; c[25] = iso; c[24] = ioc; c[23] = act;
    return c;
  endfunction

  task automatic send(input string req, input logic [31:0] c, t, input logic [2:0] k,
      input logic [11:0] n);
    logic [10:0] eml;
    @(negedge clk);
    cur_req = req;
    ctrl_in = c; token_in = t; res_kind = k; res_count = n; in_valid = 1'b1;
    #1;
    eml = 11'(t[31:21] + 1);
    checks++;
    if (tok_pid !== t[7:0] || tok_addr !== t[14:8] || tok_ep !== t[18:15] || tok_maxlen !== eml) begin
      bad++;
      $display("FAIL R1: act pid=%h a=%h ep=%h ml=%0d exp pid=%h a=%h ep=%h ml=%0d",
        tok_pid, tok_addr, tok_ep, tok_maxlen, t[7:0], t[14:8], t[18:15], eml);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; checks++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    checks++;
    if (out_valid !== 0 || ctrl_out !== 0 || wb_en !== 0 || ret_code !== 0) begin
      bad++;
      $display("FAIL R14 reset: act v=%b ctrl=%h exp v=0 ctrl=0", out_valid, ctrl_out);
    end
    send("R1", ctl(0,3,0,0,1), tok(8'h69, 7'h55, 4'hA, 11'd63), 3'd0, 12'd64);
    send("R2_R3", ctl(0,2,0,1,0), tok(8'h69, 7'h1, 4'h1, 11'd7), 3'd1, 12'd0);
    send("R4", ctl(0,3,0,1,1), tok(8'hA5, 7'h2, 4'h0, 11'd7), 3'd0, 12'd8);
    send("R5", ctl(1,3,0,0,1), tok(8'h69, 7'h3, 4'h2, 11'd7), 3'd5, 12'd0);
    send("R5_R13", ctl(0,3,1,0,1), tok(8'hE1, 7'h3, 4'h2, 11'd7), 3'd5, 12'd0);
    idle();
    send("R6", ctl(0,3,0,0,1) | 32'h0008_0000, tok(8'hE1, 7'h4, 4'h3, 11'd63), 3'd0, 12'd0);
    send("R6", ctl(0,3,0,0,1), tok(8'h2D, 7'h4, 4'h0, 11'd7), 3'd0, 12'd0);
    send("R6", ctl(1,3,0,0,1), tok(8'h69, 7'h4, 4'h1, 11'd63), 3'd0, 12'd64);
    send("R6", ctl(0,3,0,0,1), tok(8'h69, 7'h4, 4'h1, 11'd63), 3'd0, 12'd0);
    send("R7_R12", ctl(0,3,0,0,1), tok(8'h69, 7'h4, 4'h1, 11'd63), 3'd0, 12'd65);
    send("R7", ctl(0,3,0,0,1), tok(8'h69, 7'h4, 4'h1, 11'h7FF), 3'd0, 12'd0);
    send("R7", ctl(0,3,0,0,1), tok(8'h69, 7'h4, 4'h1, 11'h7FF), 3'd0, 12'd1);
    send("R8", ctl(1,3,0,1,1), tok(8'h69, 7'h5, 4'h1, 11'd63), 3'd0, 12'd10);
    send("R8", ctl(0,3,0,0,1), tok(8'h69, 7'h5, 4'h1, 11'd63), 3'd0, 12'd10);
    send("R8", ctl(1,3,0,0,1), tok(8'hE1, 7'h5, 4'h1, 11'd63), 3'd0, 12'd10);
    idle();
    send("R9", ctl(0,3,0,0,1), tok(8'hE1, 7'h6, 4'h0, 11'd7), 3'd1, 12'd0);
    send("R9", ctl(0,1,0,0,1), tok(8'hE1, 7'h6, 4'h0, 11'd7), 3'd1, 12'd0);
    send("R9", ctl(0,0,0,0,1), tok(8'hE1, 7'h6, 4'h0, 11'd7), 3'd1, 12'd0);
    send("R9", ctl(0,2,0,0,1), tok(8'h69, 7'h6, 4'h0, 11'd7), 3'd7, 12'd0);
    send("R10", ctl(0,1,0,0,1), tok(8'h69, 7'h7, 4'h0, 11'd7), 3'd2, 12'd0);
    send("R10", ctl(0,1,0,0,1), tok(8'h2D, 7'h7, 4'h0, 11'd7), 3'd2, 12'd0);
    send("R14", ctl(0,1,0,0,1) | 32'h0008_0000, tok(8'h69, 7'h7, 4'h0, 11'd7), 3'd2, 12'd0);
    send("R11", ctl(0,3,0,0,1), tok(8'hE1, 7'h8, 4'h0, 11'd7), 3'd3, 12'd0);
    send("R12", ctl(0,3,0,1,1), tok(8'hE1, 7'h8, 4'h0, 11'd7), 3'd4, 12'd0);
    send("R13", ctl(0,3,1,0,1), tok(8'h69, 7'h9, 4'h0, 11'd7), 3'd2, 12'd0);
    send("R13", ctl(0,3,1,0,1), tok(8'hE1, 7'h9, 4'h0, 11'd7), 3'd0, 12'd0);
    idle();
    idle();
    for (int i = 0; i < 600; i++) begin
      logic [7:0] pid;
      logic [31:0] c;
      int sel = $urandom_range(0, 3);
      pid = (sel == 0) ? 8'h69 : (sel == 1) ? 8'hE1 : (sel == 2) ? 8'h2D : 8'($urandom);
      c = $urandom;
      if ($urandom_range(0, 3) != 0) c[23] = 1'b1;
      send("R14_mix", c, tok(pid, 7'($urandom), 4'($urandom), 11'($urandom_range(0, 80)) | ($urandom_range(0,15) == 0 ? 11'h7FF : 11'd0)),
           3'($urandom), 12'($urandom_range(0, 90)));
      if ($urandom_range(0, 4) == 0) idle();
    end
    idle();
    idle();
    idle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule